// File: doc/BRIEF.md
# Serial Start-Frame Header Detector

This block watches one asynchronous-style serial receive line for the header of a LIN-style start frame. It first needs a break: the line must stay low for a programmable number of clock cycles. Once the line returns high it receives a first control byte as 8N1 characters, sampled at a fixed oversample ratio, and compares it against a reference value. A second control byte is then compared as a whole byte against a primary and a secondary value. When enabled, one selectable bit of that byte can instead be matched alone against the same bit of the primary value. When the header is accepted, a one-cycle pulse tells downstream logic that the information frame may begin. Any mismatch sends the detector back to waiting for a fresh break.

Three sticky status flags record break detection, first-byte match and single-bit (priority) detection. Each flag has its own clear strobe and its own interrupt enable. A single registered interrupt output combines them.

Top module: `sframe_hdr_det`

## Requirements
- R1: `flag_brk` sets once `rxd` has been sampled low on `brk_period` consecutive clock edges. A high sample before that restarts the count. A `brk_period` of 0 behaves as 1.
- R2: After a break, the detector waits for `rxd` high and then receives bytes as 8N1 characters. Each bit lasts OVS clocks and bits arrive least significant first. A character whose stop bit is low is discarded and the detector returns to idle.
- R3: A first control byte equal to `cf0_ref` sets `flag_cf0`. Any other value leaves `flag_cf0` clear and returns the detector to idle.
- R4: A second control byte equal to `cf1_pri` or to `cf1_sec` produces a one-cycle `frame_ok` pulse.
- R5: With `pri_bit_en` = 1, if bit `pri_bit_sel` (0 = LSB … 7 = MSB) of the second byte equals the same bit of `cf1_pri`, then `flag_pri` sets and `frame_ok` pulses, even when the byte matches neither compare value.
- R6: With `pri_bit_en` = 0, `flag_pri` never sets and the second byte is judged only by whole-byte compare.
- R7: A second byte that fails every enabled test gives no `frame_ok` and returns the detector to idle. Bytes arriving afterwards are ignored until a new break.
- R8: A 1 on `clr_brk`, `clr_cf0` or `clr_pri` clears the matching flag at the next edge. If a set event and a clear happen in the same cycle, the flag ends up set.
- R9: `irq` is, one cycle later, the OR of each flag ANDed with its enable. Flags set whatever their enables are.
- R10: After reset, all flags, `irq` and `frame_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line (synchronous to clk) |
| brk_period | input | TMR_W | Minimum break low width in cycles (0 acts as 1) |
| cf0_ref | input | 8 | Expected first control byte |
| cf1_pri | input | 8 | Primary compare value for the second byte |
| cf1_sec | input | 8 | Secondary compare value for the second byte |
| pri_bit_en | input | 1 | Enables the single-bit priority test |
| pri_bit_sel | input | 3 | Bit position used by the priority test |
| ie_brk | input | 1 | Interrupt enable for the break flag |
| ie_cf0 | input | 1 | Interrupt enable for the first-byte flag |
| ie_pri | input | 1 | Interrupt enable for the priority flag |
| clr_brk | input | 1 | Clear strobe for the break flag |
| clr_cf0 | input | 1 | Clear strobe for the first-byte flag |
| clr_pri | input | 1 | Clear strobe for the priority flag |
| flag_brk | output | 1 | Break detected |
| flag_cf0 | output | 1 | First control byte matched |
| flag_pri | output | 1 | Priority bit detected |
| frame_ok | output | 1 | One-cycle pulse: the information frame may begin |
| irq | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach from the ports is a set event that lands in the same cycle as a clear strobe. The edge on which the first byte is accepted is not visible from outside. The stimulus therefore holds the clear strobe high for a whole header and watches, between edges, whether the flag was ever seen high while the clear was active. A second difficult area is the boundary of the break width. Low runs of exactly one cycle short, of exactly the period, and split by a single high sample are driven, and a period of zero is also exercised.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK_MEAS,
    ST_BRK_DONE,
    ST_CF0,
    ST_CF1,
    ST_FRAME_OK
  } sfd_state_e;

  // whole-byte compare against either of two values
  function automatic logic byte_hits(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] c);
    return (b == a) || (b == c);
  endfunction

  // single selected bit compare, gated by enable
  function automatic logic bit_hits(input logic [BYTE_W-1:0] b,
                                    input logic [BYTE_W-1:0] r,
                                    input logic [SEL_W-1:0]  sel,
                                    input logic              en);
    return en && (b[sel] == r[sel]);
  endfunction
endpackage

// File: rtl/sfd_uart_rx.sv
module sfd_uart_rx
  import sfd_pkg::*;
#(
  parameter int OVS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rxd,
  output logic              byte_vld,
  output logic              byte_err,
  output logic [BYTE_W-1:0] data
);
  localparam int CW   = $clog2(OVS + 1);
  localparam int HALF = OVS / 2;
  localparam int LAST = BYTE_W + 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    phase;
  logic [BYTE_W-1:0] shreg;
  logic          sample_now;

  assign sample_now = busy && (cnt == '0);
  assign data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      phase    <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_err <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      byte_err <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (!rxd) begin
          busy  <= 1'b1;
          cnt   <= CW'(HALF);
          phase <= '0;
        end
      end else if (!sample_now) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= CW'(OVS - 1);
        if (phase == '0) begin
          if (rxd) busy <= 1'b0;
          else     phase <= 4'd1;
        end else if (phase < 4'(LAST)) begin
          shreg <= {rxd, shreg[BYTE_W-1:1]};
          phase <= phase + 1'b1;
        end else begin
          busy <= 1'b0;
          if (rxd) byte_vld <= 1'b1;
          else     byte_err <= 1'b1;
        end
      end
    end
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 4'(LAST));
  assert_vld_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(en));
endmodule

// File: rtl/sfd_brk_timer.sv
module sfd_brk_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rxd,
  input  logic [TMR_W-1:0] period,
  output logic             hit
);
  logic [TMR_W-1:0] cnt;
  logic [TMR_W:0]   next_cnt;

  function automatic logic [TMR_W-1:0] eff_period(input logic [TMR_W-1:0] p);
    return (p == '0) ? TMR_W'(1) : p;
  endfunction

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign hit = arm && !rxd && (next_cnt >= {1'b0, eff_period(period)});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!arm || rxd)  cnt <= '0;
    else if (!hit)         cnt <= next_cnt[TMR_W-1:0];
  end

  assert_hit_only_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !rxd);
  assert_high_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && rxd) |=> (cnt == '0));
endmodule

// File: rtl/sfd_hdr_fsm.sv
module sfd_hdr_fsm
  import sfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              brk_hit,
  input  logic              byte_vld,
  input  logic              byte_err,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [BYTE_W-1:0] cf0_ref,
  input  logic [BYTE_W-1:0] cf1_pri,
  input  logic [BYTE_W-1:0] cf1_sec,
  input  logic              pri_en,
  input  logic [SEL_W-1:0]  pri_sel,
  output logic              arm,
  output logic              rx_en,
  output logic              brk_set,
  output logic              cf0_set,
  output logic              pri_set,
  output logic              frame_ok
);
  sfd_state_e state, state_nx;
  logic cf1_full, cf1_bit;

  assign cf1_full = byte_hits(rx_data, cf1_pri, cf1_sec);
  assign cf1_bit  = bit_hits(rx_data, cf1_pri, pri_sel, pri_en);

  assign arm      = (state == ST_IDLE) || (state == ST_BRK_MEAS);
  assign rx_en    = (state == ST_CF0) || (state == ST_CF1);
  assign frame_ok = (state == ST_FRAME_OK);
  assign brk_set  = arm && brk_hit;
  assign cf0_set  = (state == ST_CF0) && byte_vld && (rx_data == cf0_ref);
  assign pri_set  = (state == ST_CF1) && byte_vld && cf1_bit;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (brk_hit) state_nx = ST_BRK_DONE;
                   else if (!rxd) state_nx = ST_BRK_MEAS;
      ST_BRK_MEAS: if (brk_hit) state_nx = ST_BRK_DONE;
                   else if (rxd) state_nx = ST_IDLE;
      ST_BRK_DONE: if (rxd) state_nx = ST_CF0;
      ST_CF0:      if (byte_err) state_nx = ST_IDLE;
                   else if (byte_vld)
                     state_nx = (rx_data == cf0_ref) ? ST_CF1 : ST_IDLE;
      ST_CF1:      if (byte_err) state_nx = ST_IDLE;
                   else if (byte_vld)
                     state_nx = (cf1_full || cf1_bit) ? ST_FRAME_OK : ST_IDLE;
      ST_FRAME_OK: state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assert_frame_ok_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);
  assert_pri_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pri_set |-> pri_en);
  assert_cf0_leads_cf1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cf0_set |=> (state == ST_CF1));
  assert_frame_after_cf1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_ok) |-> $past(state == ST_CF1));
endmodule

// File: rtl/sframe_hdr_det.sv
module sframe_hdr_det
  import sfd_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int OVS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [TMR_W-1:0]  brk_period,
  input  logic [7:0]        cf0_ref,
  input  logic [7:0]        cf1_pri,
  input  logic [7:0]        cf1_sec,
  input  logic              pri_bit_en,
  input  logic [2:0]        pri_bit_sel,
  input  logic              ie_brk,
  input  logic              ie_cf0,
  input  logic              ie_pri,
  input  logic              clr_brk,
  input  logic              clr_cf0,
  input  logic              clr_pri,
  output logic              flag_brk,
  output logic              flag_cf0,
  output logic              flag_pri,
  output logic              frame_ok,
  output logic              irq
);
  localparam int NFLAG = 3;

  logic brk_hit, arm, rx_en, byte_vld, byte_err;
  logic brk_set, cf0_set, pri_set;
  logic [BYTE_W-1:0] rx_data;
  logic [NFLAG-1:0]  flags, set_v, clr_v, ie_v;
  logic              irq_nx;

  sfd_brk_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rxd(rxd),
    .period(brk_period), .hit(brk_hit)
  );

  sfd_uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .rxd(rxd),
    .byte_vld(byte_vld), .byte_err(byte_err), .data(rx_data)
  );

  sfd_hdr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .brk_hit(brk_hit),
    .byte_vld(byte_vld), .byte_err(byte_err), .rx_data(rx_data),
    .cf0_ref(cf0_ref), .cf1_pri(cf1_pri), .cf1_sec(cf1_sec),
    .pri_en(pri_bit_en), .pri_sel(pri_bit_sel),
    .arm(arm), .rx_en(rx_en), .brk_set(brk_set), .cf0_set(cf0_set),
    .pri_set(pri_set), .frame_ok(frame_ok)
  );

  assign set_v = {pri_set, cf0_set, brk_set};
  assign clr_v = {clr_pri, clr_cf0, clr_brk};
  assign ie_v  = {ie_pri, ie_cf0, ie_brk};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_v[i] | (flags[i] & ~clr_v[i]);
    end
  end

  assign irq_nx = |(flags & ie_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nx;
  end

  assign flag_brk = flags[0];
  assign flag_cf0 = flags[1];
  assign flag_pri = flags[2];

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cf0_set && clr_cf0) |=> flag_cf0);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_brk && !brk_set) |=> !flag_brk);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_pri && ie_pri) |=> irq);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_brk && ie_brk) && !(flag_cf0 && ie_cf0) && !(flag_pri && ie_pri) |=> !irq);
  assert_brk_flag_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_brk) |-> $past(brk_hit));
endmodule

// File: tb/sframe_hdr_det_tb.sv
module sframe_hdr_det_tb;
  localparam int TMR_W = 16;
  localparam int OVS   = 4;
  localparam int BRK   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [TMR_W-1:0] brk_period = TMR_W'(BRK);
  logic [7:0] cf0_ref = 8'hA5, cf1_pri = 8'h3C, cf1_sec = 8'hC3;
  logic pri_bit_en = 1'b0;
  logic [2:0] pri_bit_sel = 3'd0;
  logic ie_brk = 1'b0, ie_cf0 = 1'b0, ie_pri = 1'b0;
  logic clr_brk = 1'b0, clr_cf0 = 1'b0, clr_pri = 1'b0;
  logic flag_brk, flag_cf0, flag_pri, frame_ok, irq;

  int checks = 0;
  int fails = 0;
  int frames = 0;
  int cycles = 0;
  bit seen_set_clr = 1'b0;

  always #10 clk = ~clk;

  sframe_hdr_det #(.TMR_W(TMR_W), .OVS(OVS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .brk_period(brk_period),
    .cf0_ref(cf0_ref), .cf1_pri(cf1_pri), .cf1_sec(cf1_sec),
    .pri_bit_en(pri_bit_en), .pri_bit_sel(pri_bit_sel),
    .ie_brk(ie_brk), .ie_cf0(ie_cf0), .ie_pri(ie_pri),
    .clr_brk(clr_brk), .clr_cf0(clr_cf0), .clr_pri(clr_pri),
    .flag_brk(flag_brk), .flag_cf0(flag_cf0), .flag_pri(flag_pri),
    .frame_ok(frame_ok), .irq(irq)
  );

  always @(posedge clk) if (frame_ok) frames++;
  always @(negedge clk) if (flag_cf0 && clr_cf0) seen_set_clr = 1'b1;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop);
    hold(1'b0, OVS);
    for (int i = 0; i < 8; i++) hold(b[i], OVS);
    hold(stop, OVS);
    hold(1'b1, 2 * OVS);
  endtask

  task automatic send_break();
    hold(1'b0, BRK + 3);
    hold(1'b1, 5);
  endtask

  task automatic clear_all();
    clr_brk = 1'b1; clr_cf0 = 1'b1; clr_pri = 1'b1;
    @(negedge clk);
    clr_brk = 1'b0; clr_cf0 = 1'b0; clr_pri = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rxd = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // [31:24] cf0 byte, [23:16] cf1 byte, [15] pri_en, [14:12] sel,
  // [2] exp flag_cf0, [1] exp flag_pri, [0] exp frame_ok
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {8'hA5, 8'h3C, 1'b0, 3'd0, 9'd0, 3'b101},
    {8'hA5, 8'hC3, 1'b0, 3'd0, 9'd0, 3'b101},
    {8'hA5, 8'h00, 1'b0, 3'd0, 9'd0, 3'b100},
    {8'hA5, 8'h00, 1'b1, 3'd0, 9'd0, 3'b111},
    {8'hA5, 8'h01, 1'b1, 3'd0, 9'd0, 3'b100},
    {8'hA5, 8'h20, 1'b1, 3'd5, 9'd0, 3'b111},
    {8'hA5, 8'hDF, 1'b1, 3'd5, 9'd0, 3'b100},
    {8'h5A, 8'h3C, 1'b1, 3'd0, 9'd0, 3'b000},
    {8'hA5, 8'h3C, 1'b1, 3'd7, 9'd0, 3'b111},
    {8'hA5, 8'h80, 1'b1, 3'd7, 9'd0, 3'b100}
  };

  initial begin
    do_reset();
    // R10: reset state
    check("R10 flag_brk", flag_brk, 0);
    check("R10 flag_cf0", flag_cf0, 0);
    check("R10 flag_pri", flag_pri, 0);
    check("R10 irq", irq, 0);
    check("R10 frame_ok", frame_ok, 0);

    // table walk: R3 R4 R5 R6 R7 R9
    ie_pri = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int f0;
      pri_bit_en  = VEC[v][15];
      pri_bit_sel = VEC[v][14:12];
      clear_all();
      f0 = frames;
      send_break();
      send_byte(VEC[v][31:24], 1'b1);
      send_byte(VEC[v][23:16], 1'b1);
      hold(1'b1, 3 * OVS);
      check($sformatf("R1 vec%0d flag_brk", v), flag_brk, 1);
      check($sformatf("R3 vec%0d flag_cf0", v), flag_cf0, VEC[v][2]);
      check($sformatf("R5/R6 vec%0d flag_pri", v), flag_pri, VEC[v][1]);
      check($sformatf("R4/R7 vec%0d frame_ok", v), frames - f0, VEC[v][0]);
      check($sformatf("R9 vec%0d irq", v), irq, VEC[v][1]);
    end
    ie_pri = 1'b0;

    // R9: flag already set regardless of enable; enabling raises irq
    @(negedge clk); @(negedge clk);
    check("R9 irq off", irq, 0);
    ie_brk = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 irq on brk", irq, 1);
    ie_brk = 1'b0;

    // R8: plain clear
    clear_all();
    check("R8 clear brk", flag_brk, 0);
    check("R8 clear cf0", flag_cf0, 0);

    // R1: boundary widths
    do_reset();
    hold(1'b0, BRK - 1); hold(1'b1, 3);
    check("R1 one short", flag_brk, 0);
    hold(1'b0, 10); hold(1'b1, 1); hold(1'b0, 10); hold(1'b1, 3);
    check("R1 restart", flag_brk, 0);
    hold(1'b0, BRK); hold(1'b1, 3);
    check("R1 exact", flag_brk, 1);
    do_reset();
    brk_period = '0;
    hold(1'b0, 1); hold(1'b1, 3);
    check("R1 period zero", flag_brk, 1);
    brk_period = TMR_W'(BRK);

    // R2: bad stop bit discards the first byte
    do_reset();
    send_break();
    send_byte(8'hA5, 1'b0);
    hold(1'b1, 3 * OVS);
    check("R2 stop error", flag_cf0, 0);

    // R7: after a first-byte mismatch, bytes without a break are ignored
    do_reset();
    begin
      int f0;
      f0 = frames;
      send_break();
      send_byte(8'h11, 1'b1);
      send_byte(8'hA5, 1'b1);
      send_byte(8'h3C, 1'b1);
      hold(1'b1, 3 * OVS);
      check("R7 ignored cf0", flag_cf0, 0);
      check("R7 ignored frame", frames - f0, 0);
    end

    // R6: whole-byte match with pri disabled leaves flag_pri clear
    do_reset();
    pri_bit_en = 1'b0; pri_bit_sel = 3'd2;
    send_break();
    send_byte(8'hA5, 1'b1);
    send_byte(8'h3C, 1'b1);
    hold(1'b1, 3 * OVS);
    check("R6 no pri flag", flag_pri, 0);

    // R8: set wins over a clear held through the header
    do_reset();
    seen_set_clr = 1'b0;
    clr_cf0 = 1'b1;
    send_break();
    send_byte(8'hA5, 1'b1);
    hold(1'b1, 3 * OVS);
    check("R8 set wins", seen_set_clr, 1);
    check("R8 cleared after", flag_cf0, 0);
    clr_cf0 = 1'b0;

    summary();
  end
endmodule